// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache Controller

This block is the level-one data cache of a 64-bit processor. It holds 16 KB in two ways of 32-byte lines, which gives four doublewords per line and 256 sets. The set is chosen from virtual address bits that the core supplies. The hit comparison uses a physical tag that arrives with the same access, so translation can run in parallel with the array lookup. Each access also carries a policy bit that selects write-back or write-through handling for that access alone. A two-bit lock input can pin either way so that it is never chosen for replacement.

The core raises a read or a write request and holds the index, tag, policy, byte enables and store data steady until `cpu_ready` pulses for one cycle. Hits complete without any memory traffic. On a miss, a dirty victim is first written out as a four-beat burst. The line is then requested with the missed doubleword first, and the remaining beats wrap through the line. The stalled access is released on the first returned beat, and the rest of the line fills while the core moves on. The memory port is a single request/acknowledge channel. The controller holds each beat until the memory acknowledges it, and a flag distinguishes whole-line bursts from single-doubleword transfers.

Top module: `dcache_2way`

## Requirements
- R1: After reset no line is valid, `cpu_ready` and `mem_req` are low, and the first access to any address misses.
- R2: `cpu_idx` selects the set from its upper 8 bits and the doubleword from its low 2 bits. A read whose `cpu_ptag` equals the tag of a valid way returns that doubleword with `cpu_ready` in the cycle after acceptance, and it causes no memory request.
- R3: A write-back store (`cpu_wb`=1) that hits replaces only the bytes whose `cpu_be` bit is set (bit i covers data bits 8i+7..8i), marks the line dirty and makes no memory request.
- R4: A write-through store (`cpu_wb`=0) sends exactly one single-doubleword write with its byte enables to memory. On a hit it also updates the cached copy. On a miss it allocates nothing.
- R5: A read miss requests the line starting at the missed doubleword, with later beats wrapping modulo four. `cpu_ready` and the requested data appear after the first beat, before the remaining beats are returned.
- R6: Each set keeps one least-recently-used bit. Every hit or fill marks the other way as least recently used, and a miss replaces the least recently used way.
- R7: A way whose `lock_way` bit is set is never replaced. If the least recently used way is locked, the other way is the victim.
- R8: With both ways locked, a miss that would allocate is served as one uncached single-doubleword read or write, and no line is filled.
- R9: A dirty valid victim is written to memory as a four-beat burst at beats 0,1,2,3 of its old address. This happens before the refill request.
- R10: A write-back store miss allocates a line by refill, merges its bytes into the missed doubleword, and leaves the line dirty.
- R11: An access presented while a refill is still completing is not answered until the whole line has been returned.
- R12: `cpu_ready` is a single-cycle pulse; it is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Load request, held until ready |
| cpu_wr | input | 1 | Store request, held until ready |
| cpu_idx | input | 10 | Virtual set (upper 8) and doubleword (lower 2) index |
| cpu_ptag | input | 19 | Physical tag of the access |
| cpu_wb | input | 1 | 1 = write-back, 0 = write-through for this access |
| cpu_be | input | 8 | Store byte enables |
| cpu_wdata | input | 64 | Store data |
| cpu_rdata | output | 64 | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| lock_way | input | 2 | Per-way replacement lock |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write transfer |
| mem_line | output | 1 | 1 = four-beat line burst, 0 = single doubleword |
| mem_addr | output | 29 | Doubleword address {tag, set, doubleword} |
| mem_wdata | output | 64 | Write beat data |
| mem_be | output | 8 | Write byte enables |
| mem_ack | input | 1 | Memory accepted or returned one beat |
| mem_rdata | input | 64 | Read beat data |

## Verification
A corrupted tag, valid or LRU bit shows up on the next access to that set. The access either produces memory traffic that a hit should not cause, or it returns stale data or replaces the wrong way. That way's later hits then turn into misses one or two accesses afterwards. A lost dirty bit does not show until that line is evicted, when the expected writeback burst is missing. The difference then shows in the memory contents that the final sweep compares. A fault in the early-release path shows in the same access, as a ready pulse that arrives after more than one refill beat or lands while an earlier burst is still active.

// File: rtl/dcache_2way.sv
module dcache_2way #(
  parameter int CACHE_BYTES = 16384,
  parameter int LINE_DW     = 4,
  parameter int TAG_W       = 19,
  localparam int SETS   = CACHE_BYTES / (2 * LINE_DW * 8),
  localparam int SET_W  = $clog2(SETS),
  localparam int DW_W   = $clog2(LINE_DW),
  localparam int IDX_W  = SET_W + DW_W,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [TAG_W-1:0]  cpu_ptag,
  input  logic              cpu_wb,
  input  logic [7:0]        cpu_be,
  input  logic [63:0]       cpu_wdata,
  output logic [63:0]       cpu_rdata,
  output logic              cpu_ready,
  input  logic [1:0]        lock_way,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_line,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  output logic [7:0]        mem_be,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata
);

  localparam logic [DW_W-1:0] LAST = DW_W'(LINE_DW - 1);

  typedef enum logic [2:0] {S_IDLE, S_RESP, S_WB, S_RF, S_SW, S_SR} st_t;

  st_t st;

  logic [TAG_W-1:0] tag_q [2][SETS];
  logic [63:0]      dat_q [2][SETS*LINE_DW];
  logic [1:0]       vld_q [SETS];
  logic [1:0]       dty_q [SETS];
  logic [SETS-1:0]  lru_q;

  logic [SET_W-1:0] r_set;
  logic [DW_W-1:0]  r_dw, cnt;
  logic [TAG_W-1:0] r_tag;
  logic [7:0]       r_be;
  logic [63:0]      r_wdata, rdata_q;
  logic             r_wr, r_wb, r_way, ready_q;

  function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] n,
                                        input logic [7:0] be);
    logic [63:0] m;
    for (int i = 0; i < 8; i++) m[8*i +: 8] = be[i] ? n[8*i +: 8] : o[8*i +: 8];
    return m;
  endfunction

  wire [SET_W-1:0] set  = cpu_idx[IDX_W-1:DW_W];
  wire [DW_W-1:0]  dwi  = cpu_idx[DW_W-1:0];
  wire             acc  = (st == S_IDLE) && (cpu_rd || cpu_wr);
  wire             is_wr = cpu_wr && !cpu_rd;
  wire             hit0 = vld_q[set][0] && (tag_q[0][set] == cpu_ptag);
  wire             hit1 = vld_q[set][1] && (tag_q[1][set] == cpu_ptag);
  wire             hit  = hit0 || hit1;
  wire             hway = hit1;
  wire             lru_w = lru_q[set];
  wire             vic  = lock_way[lru_w] ? ~lru_w : lru_w;
  wire             vic_dirty = vld_q[set][vic] && dty_q[set][vic];
  wire             wr_hit = acc && is_wr && hit;
  wire             fill_beat = (st == S_RF) && mem_ack;
  wire [DW_W-1:0]  rf_dw = r_dw + cnt;
  wire [63:0]      rf_word = (cnt == '0 && r_wr) ? merge(mem_rdata, r_wdata, r_be) : mem_rdata;

  always_ff @(posedge clk) begin
    if (wr_hit)
      dat_q[hway][{set, dwi}] <= merge(dat_q[hway][{set, dwi}], cpu_wdata, cpu_be);
    if (fill_beat)
      dat_q[r_way][{r_set, rf_dw}] <= rf_word;
    if (fill_beat && cnt == LAST)
      tag_q[r_way][r_set] <= r_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ready_q <= 1'b0;
      rdata_q <= '0;
      cnt     <= '0;
      r_set   <= '0;
      r_dw    <= '0;
      r_tag   <= '0;
      r_be    <= '0;
      r_wdata <= '0;
      r_wr    <= 1'b0;
      r_wb    <= 1'b0;
      r_way   <= 1'b0;
      lru_q   <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        dty_q[s] <= '0;
      end
    end else begin
      ready_q <= 1'b0;
      case (st)
        S_IDLE: if (acc) begin
          r_set   <= set;
          r_dw    <= dwi;
          r_tag   <= cpu_ptag;
          r_be    <= cpu_be;
          r_wdata <= cpu_wdata;
          r_wr    <= is_wr;
          r_wb    <= cpu_wb;
          cnt     <= '0;
          if (hit) begin
            lru_q[set] <= ~hway;
            if (!is_wr) begin
              rdata_q <= dat_q[hway][{set, dwi}];
              ready_q <= 1'b1;
              st      <= S_RESP;
            end else if (cpu_wb) begin
              dty_q[set][hway] <= 1'b1;
              ready_q <= 1'b1;
              st      <= S_RESP;
            end else begin
              st <= S_SW;
            end
          end else if ((is_wr && !cpu_wb) || (&lock_way)) begin
            st <= is_wr ? S_SW : S_SR;
          end else begin
            r_way <= vic;
            st    <= vic_dirty ? S_WB : S_RF;
          end
        end
        S_RESP: st <= S_IDLE;
        S_WB: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            dty_q[r_set][r_way] <= 1'b0;
            vld_q[r_set][r_way] <= 1'b0;
            st <= S_RF;
          end
        end
        S_RF: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          if (cnt == '0) begin
            rdata_q <= mem_rdata;
            ready_q <= 1'b1;
          end
          if (cnt == LAST) begin
            vld_q[r_set][r_way] <= 1'b1;
            dty_q[r_set][r_way] <= r_wr;
            lru_q[r_set]        <= ~r_way;
            st <= S_IDLE;
          end
        end
        S_SW: if (mem_ack) begin
          ready_q <= 1'b1;
          st      <= S_RESP;
        end
        S_SR: if (mem_ack) begin
          rdata_q <= mem_rdata;
          ready_q <= 1'b1;
          st      <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cpu_ready = ready_q;
  assign cpu_rdata = rdata_q;
  assign mem_req   = (st == S_WB) || (st == S_RF) || (st == S_SW) || (st == S_SR);
  assign mem_we    = (st == S_WB) || (st == S_SW);
  assign mem_line  = (st == S_WB) || (st == S_RF);
  assign mem_addr  = (st == S_WB) ? {tag_q[r_way][r_set], r_set, cnt} : {r_tag, r_set, r_dw};
  assign mem_wdata = (st == S_WB) ? dat_q[r_way][{r_set, cnt}] : r_wdata;
  assign mem_be    = (st == S_SW) ? r_be : 8'hff;

  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> $onehot0({hit1, hit0}));

  p_early_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RF && mem_ack && cnt == '0) |=> (cpu_ready && st == S_RF));

  p_locked_never_victim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_line) |-> !lock_way[r_way]);

  p_clean_before_refill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RF) |-> !(vld_q[r_set][r_way] && dty_q[r_set][r_way]));

  p_wt_no_alloc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && r_wr && !r_wb) |-> !mem_line);

  p_ready_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

endmodule

// File: tb/dcache_2way_test.sv
module dcache_2way_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_wb = 1'b0;
  logic [9:0]  cpu_idx = '0;
  logic [18:0] cpu_ptag = '0;
  logic [7:0]  cpu_be = '0;
  logic [63:0] cpu_wdata = '0;
  logic [63:0] cpu_rdata;
  logic        cpu_ready;
  logic [1:0]  lock_r = 2'b00;
  logic        mem_req, mem_we, mem_line;
  logic [28:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #5 clk = ~clk;

  dcache_2way uut (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_idx(cpu_idx),
    .cpu_ptag(cpu_ptag), .cpu_wb(cpu_wb), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .lock_way(lock_r),
    .mem_req(mem_req), .mem_we(mem_we), .mem_line(mem_line), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_cmp = 0, n_bad = 0;
  logic [63:0] backing [4096];
  logic [63:0] xm      [4096];

  bit          m_vld   [2][256];
  bit          m_dty   [2][256];
  int          m_tag   [2][256];
  int          m_lru   [256];
  logic [63:0] m_data  [2][256][4];

  int n_lr, n_lw, n_sr, n_sw, rf_beats, first_dw, order_err = 0, wb_addr_err = 0;
  bit burst_active = 1'b0;
  bit done = 1'b0;

  function automatic logic [63:0] mrg(input logic [63:0] o, input logic [63:0] n,
                                      input logic [7:0] be);
    logic [63:0] m;
    for (int i = 0; i < 8; i++) m[8*i +: 8] = be[i] ? n[8*i +: 8] : o[8*i +: 8];
    return m;
  endfunction

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic serve();
    bit line = mem_line;
    bit we = mem_we;
    logic [28:0] base = mem_addr;
    int nb = line ? 4 : 1;
    if (line && !we) begin
      n_lr++; burst_active = 1'b1; rf_beats = 0; first_dw = int'(base[1:0]);
    end else if (line) begin
      n_lw++;
      if (n_lr > 0) order_err++;
    end else if (we) n_sw++;
    else n_sr++;
    repeat ($urandom % 3) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      if (k > 0) @(negedge clk);
      if (mem_we) begin
        if (line && int'(mem_addr[1:0]) != k) wb_addr_err++;
        backing[mem_addr[11:0]] = mrg(backing[mem_addr[11:0]], mem_wdata, mem_be);
      end else begin
        logic [11:0] a;
        a = {base[11:2], base[1:0] + 2'(k)};
        mem_rdata = backing[a];
        if (line) rf_beats = k + 1;
      end
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
    end
    burst_active = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) serve();
    end
  end

  task automatic model(input bit rd, input int set, input int dw, input int tag, input bit wb,
                       input logic [7:0] be, input logic [63:0] wd,
                       output logic [63:0] er, output int elr, output int elw,
                       output int esr, output int esw, output bit efill, output string lbl);
    int h = -1;
    int v;
    int ix = tag * 1024 + set * 4 + dw;
    elr = 0; elw = 0; esr = 0; esw = 0; efill = 1'b0; er = '0;
    for (int w = 0; w < 2; w++) if (m_vld[w][set] && m_tag[w][set] == tag) h = w;
    if (h >= 0) begin
      m_lru[set] = 1 - h;
      if (rd) begin er = m_data[h][set][dw]; lbl = "R2"; end
      else begin
        m_data[h][set][dw] = mrg(m_data[h][set][dw], wd, be);
        if (wb) begin m_dty[h][set] = 1'b1; lbl = "R3"; end
        else begin esw = 1; xm[ix] = mrg(xm[ix], wd, be); lbl = "R4"; end
      end
      return;
    end
    if (!rd && !wb) begin esw = 1; xm[ix] = mrg(xm[ix], wd, be); lbl = "R4"; return; end
    if (lock_r == 2'b11) begin
      lbl = "R8";
      if (rd) begin esr = 1; er = xm[ix]; end
      else begin esw = 1; xm[ix] = mrg(xm[ix], wd, be); end
      return;
    end
    v = m_lru[set];
    if (lock_r[v]) v = 1 - v;
    lbl = rd ? "R5" : "R10";
    if (m_vld[v][set] && m_dty[v][set]) begin
      elw = 1; lbl = "R9";
      for (int d = 0; d < 4; d++) xm[m_tag[v][set] * 1024 + set * 4 + d] = m_data[v][set][d];
    end
    elr = 1; efill = 1'b1;
    for (int d = 0; d < 4; d++) m_data[v][set][d] = xm[tag * 1024 + set * 4 + d];
    if (rd) er = m_data[v][set][dw];
    else m_data[v][set][dw] = mrg(m_data[v][set][dw], wd, be);
    m_vld[v][set] = 1'b1; m_tag[v][set] = tag; m_dty[v][set] = !rd; m_lru[set] = 1 - v;
  endtask

  task automatic do_access(input bit rd, input int set, input int dw, input int tag,
                           input bit wb, input logic [7:0] be, input logic [63:0] wd,
                           input string tagname);
    logic [63:0] er, got;
    int elr, elw, esr, esw, beats_at;
    bit efill, burst_at;
    string lbl;
    n_lr = 0; n_lw = 0; n_sr = 0; n_sw = 0;
    cpu_idx = {8'(set), 2'(dw)}; cpu_ptag = 19'(tag); cpu_wb = wb; cpu_be = be;
    cpu_wdata = wd; cpu_rd = rd; cpu_wr = !rd;
    model(rd, set, dw, tag, wb, be, wd, er, elr, elw, esr, esw, efill, lbl);
    if (tagname != "") lbl = tagname;
    forever begin
      @(negedge clk);
      if (cpu_ready) break;
    end
    got = cpu_rdata; beats_at = rf_beats; burst_at = burst_active;
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    if (rd) chk(got === er, lbl, "load data", got, er);
    chk(n_lr == elr && n_lw == elw && n_sr == esr && n_sw == esw, lbl, "memory traffic lr/lw/sr/sw",
        64'({n_lr[7:0], n_lw[7:0], n_sr[7:0], n_sw[7:0]}),
        64'({elr[7:0], elw[7:0], esr[7:0], esw[7:0]}));
    if (efill) begin
      chk(beats_at == 1, "R5", "refill beats before release", 64'(beats_at), 64'd1);
      chk(first_dw == dw, "R5", "first refill doubleword", 64'(first_dw), 64'(dw));
    end else begin
      chk(!burst_at, "R11", "released during active refill", 64'(burst_at), 64'd0);
    end
    @(negedge clk);
    chk(!cpu_ready, "R12", "ready longer than one cycle", 64'(cpu_ready), 64'd0);
  endtask

  task automatic set_lock(input logic [1:0] l);
    while (mem_req || burst_active) @(negedge clk);
    lock_r = l;
  endtask

  task automatic finish_run();
    int mis = 0;
    while (mem_req || burst_active) @(negedge clk);
    for (int i = 0; i < 4096; i++) if (backing[i] !== xm[i]) mis++;
    chk(mis == 0, "R9", "memory image mismatches", 64'(mis), 64'd0);
    chk(order_err == 0, "R9", "writeback after refill", 64'(order_err), 64'd0);
    chk(wb_addr_err == 0, "R9", "writeback beat order", 64'(wb_addr_err), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1'b1;
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < 4096; i++) begin
      backing[i] = {32'(i) * 32'h9e37_79b9, ~32'(i) ^ 32'h1357_2468};
      xm[i] = backing[i];
    end
    for (int s = 0; s < 256; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < 2; w++) begin m_vld[w][s] = 1'b0; m_dty[w][s] = 1'b0; m_tag[w][s] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_ready, "R1", "ready after reset", 64'(cpu_ready), 64'd0);
    chk(!mem_req, "R1", "mem_req after reset", 64'(mem_req), 64'd0);

    do_access(1, 5, 2, 1, 1, 8'h00, '0, "R1");
    do_access(1, 5, 2, 1, 1, 8'h00, '0, "R2");
    do_access(0, 5, 1, 1, 1, 8'h0f, 64'hdead_beef_cafe_f00d, "R3");
    do_access(1, 5, 1, 1, 1, 8'h00, '0, "R3");
    do_access(1, 5, 0, 2, 1, 8'h00, '0, "R6");
    do_access(1, 5, 3, 1, 1, 8'h00, '0, "R6");
    do_access(1, 5, 0, 3, 1, 8'h00, '0, "R6");
    do_access(1, 5, 1, 1, 1, 8'h00, '0, "R6");
    set_lock(2'b01);
    do_access(1, 5, 0, 3, 1, 8'h00, '0, "R7");
    do_access(1, 5, 2, 2, 1, 8'h00, '0, "R7");
    do_access(1, 5, 1, 1, 1, 8'h00, '0, "R7");
    set_lock(2'b11);
    do_access(1, 5, 3, 0, 1, 8'h00, '0, "R8");
    do_access(0, 5, 3, 0, 1, 8'hf0, 64'h1111_2222_3333_4444, "R8");
    do_access(1, 5, 3, 0, 1, 8'h00, '0, "R8");
    set_lock(2'b00);
    do_access(1, 5, 0, 2, 1, 8'h00, '0, "R9");
    do_access(1, 5, 2, 3, 1, 8'h00, '0, "R9");
    do_access(0, 9, 1, 2, 0, 8'hff, 64'h0123_4567_89ab_cdef, "R4");
    do_access(1, 9, 1, 2, 1, 8'h00, '0, "R4");
    do_access(0, 9, 1, 2, 0, 8'h3c, 64'haaaa_bbbb_cccc_dddd, "R4");
    do_access(1, 9, 1, 2, 1, 8'h00, '0, "R4");
    do_access(0, 12, 2, 1, 1, 8'h81, 64'h7777_8888_9999_aaaa, "R10");
    do_access(1, 12, 2, 1, 1, 8'h00, '0, "R10");
    do_access(1, 20, 3, 0, 1, 8'h00, '0, "R5");
    do_access(1, 12, 2, 1, 1, 8'h00, '0, "R11");

    for (int n = 0; n < 2000; n++) begin
      if ($urandom % 20 == 0) set_lock(2'(($urandom % 8 == 0) ? 3 : ($urandom % 3)));
      do_access($urandom % 2, ($urandom % 8 == 0) ? int'($urandom % 256) : int'($urandom % 4),
                int'($urandom % 4), int'($urandom % 4), ($urandom % 4) != 0,
                8'($urandom), {$urandom, $urandom}, "");
    end
    finish_run();
  end
endmodule